// File: doc/BRIEF.md
# Timed Output Event Register Front End

This block sits between a processor's register bus and the event path of a timed output system. Software composes one output event in a small register file: it picks a destination channel, loads a 64-bit event time in two halves, sets a target address and fills one or more 32-bit payload words. A write to the commit register then either hands the event to a downstream consumer over a valid/ready port or rejects it.

An event is rejected when its time is already in the past relative to a free-running 64-bit time counter, or when the downstream link is reported down. The outcome shows in a three-bit status register: a busy bit while the event waits for the consumer, and two sticky error bits. A snapshot register lets software sample the time counter coherently, and a control register restarts the counter and clears the error bits.

Loading a new time wipes every payload word, so a short event never carries leftover payload from the previous one. Payload words are placed in reverse address order: word 0 sits at the highest payload address.

Top module: `evt_out_regif`

## Requirements
- R1: After reset the status register reads 0, `ev_valid` is low, all payload words read 0 and the snapshot reads 0.
- R2: With payload base address 0x10 and N_WORDS words, word i is written and read at address 0x10 + N_WORDS - 1 - i and is carried on `ev_data[32*i +: 32]`.
- R3: A write to either time half (0x02 low, 0x03 high) sets every payload word to 0 in the following cycle.
- R4: A write to the commit register (0x05) with `link_up` high and event time not earlier than the time counter at that edge raises `ev_valid` in the next cycle with the channel (0x01), address (0x04), time and payload registers, and status bit 0 (busy) reads 1.
- R5: While `ev_valid` is high and `ev_ready` is low, `ev_valid` and all event fields hold; the cycle after a transfer `ev_valid` is low and status bit 0 reads 0.
- R6: If the event time is earlier than the time counter at the commit edge, no event is issued and status bit 1 (value 2) is set; an event time equal to the counter is accepted.
- R7: If `link_up` is low at the commit edge, no event is issued and status bit 2 (value 4) is set.
- R8: Status bits 1 and 2 stay set until the next accepted commit, which replaces them with the outcome of that commit.
- R9: A commit write while an event is still waiting is ignored: the pending event, its fields and the status flags stay unchanged and no second event follows.
- R10: The time counter advances by one each cycle; a write to 0x07 copies its value into the snapshot (0x08 low, 0x09 high), which otherwise holds.
- R11: A write to the control register (0x00) with bit 0 set returns the time counter to 0 and clears status bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| link_up | input | 1 | Downstream link usable |
| ev_valid | output | 1 | Event presented to consumer |
| ev_ready | input | 1 | Consumer accepts event |
| ev_chan | output | CH_W | Event channel |
| ev_addr | output | EV_AW | Event target address |
| ev_time | output | 64 | Event time |
| ev_data | output | 32*N_WORDS | Event payload, word i at bits 32*i upward |

## Verification
Events are built with random channel, address and payload and with times set relative to a counter value read back through the snapshot, at offsets of -3 to +3 around the commit-edge count and far in the future. The offsets straddling zero separate a strict from a non-strict late comparison and an off-by-one in the counter sampling, while far-future times check the high time half. Random consumer stall lengths separate a port that holds its event from one that drops or changes it, and occasional link-down commits separate the link flag from the late flag. Directed cases cover payload clearing by either time half, reversed word placement, ignored commits while busy, flag stickiness and the control restart.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] A_CTRL    = 5'h00;
  localparam logic [REG_AW-1:0] A_CHSEL   = 5'h01;
  localparam logic [REG_AW-1:0] A_TIME_LO = 5'h02;
  localparam logic [REG_AW-1:0] A_TIME_HI = 5'h03;
  localparam logic [REG_AW-1:0] A_TADDR   = 5'h04;
  localparam logic [REG_AW-1:0] A_COMMIT  = 5'h05;
  localparam logic [REG_AW-1:0] A_STATUS  = 5'h06;
  localparam logic [REG_AW-1:0] A_SNAPREQ = 5'h07;
  localparam logic [REG_AW-1:0] A_SNAP_LO = 5'h08;
  localparam logic [REG_AW-1:0] A_SNAP_HI = 5'h09;
  localparam logic [REG_AW-1:0] A_PAYLOAD = 5'h10;

  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_LATE = 1;
  localparam int unsigned ST_LINK = 2;

  // Payload word idx lives at the mirrored slot from the top of the window.
  function automatic logic [REG_AW-1:0] payload_slot(int unsigned idx, int unsigned n);
    return REG_AW'(int'(A_PAYLOAD) + int'(n) - 1 - int'(idx));
  endfunction

  // An event is late when its time lies strictly before the counter.
  function automatic logic is_late(logic [63:0] ev_t, logic [63:0] now);
    return ev_t < now;
  endfunction
endpackage

// File: rtl/evt_time_counter.sv
module evt_time_counter #(
  parameter int unsigned CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          snap_req,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] snap_o
);
  logic [CW-1:0] count_q;
  logic [CW-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      snap_q  <= '0;
    end else begin
      count_q <= clr ? '0 : count_q + CW'(1);
      if (snap_req) snap_q <= count_q;
    end
  end

  assign count_o = count_q;
  assign snap_o  = snap_q;

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> count_q == $past(count_q) + CW'(1));
  assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> $stable(snap_q));
  assert_clear_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count_q == '0);
endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
  import evt_pkg::*;
#(
  parameter int unsigned N_WORDS = 2,
  parameter int unsigned CH_W    = 8,
  parameter int unsigned EV_AW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  output logic [CH_W-1:0]       chsel_o,
  output logic [63:0]           time_o,
  output logic [EV_AW-1:0]      taddr_o,
  output logic [32*N_WORDS-1:0] payload_o,
  output logic                  time_wr_o
);
  logic [CH_W-1:0]  chsel_q;
  logic [63:0]      time_q;
  logic [EV_AW-1:0] taddr_q;

  // Named event: any write to either half of the time register.
  assign time_wr_o = wr_en && (wr_addr == A_TIME_LO || wr_addr == A_TIME_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chsel_q <= '0;
      time_q  <= '0;
      taddr_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CHSEL:   chsel_q       <= wr_data[CH_W-1:0];
        A_TIME_LO: time_q[31:0]  <= wr_data;
        A_TIME_HI: time_q[63:32] <= wr_data;
        A_TADDR:   taddr_q       <= wr_data[EV_AW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    localparam logic [REG_AW-1:0] SLOT = payload_slot(g, N_WORDS);
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          word_q <= '0;
      else if (time_wr_o)                  word_q <= '0;
      else if (wr_en && wr_addr == SLOT)   word_q <= wr_data;
    end
    assign payload_o[32*g +: 32] = word_q;
  end

  assign chsel_o = chsel_q;
  assign time_o  = time_q;
  assign taddr_o = taddr_q;

  assert_time_wipes_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_o |=> payload_o == '0);
endmodule

// File: rtl/evt_commit.sv
module evt_commit
  import evt_pkg::*;
#(
  parameter int unsigned N_WORDS = 2,
  parameter int unsigned CH_W    = 8,
  parameter int unsigned EV_AW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit_req,
  input  logic                  flag_clr,
  input  logic [63:0]           now,
  input  logic                  link_up,
  input  logic [CH_W-1:0]       chsel,
  input  logic [63:0]           ev_t,
  input  logic [EV_AW-1:0]      taddr,
  input  logic [32*N_WORDS-1:0] payload,
  output logic                  ev_valid,
  input  logic                  ev_ready,
  output logic [CH_W-1:0]       ev_chan,
  output logic [EV_AW-1:0]      ev_addr,
  output logic [63:0]           ev_time,
  output logic [32*N_WORDS-1:0] ev_data,
  output logic [2:0]            status_o
);
  logic valid_q, late_q, link_q;
  logic fire, late_w, link_bad, issue;

  assign fire     = commit_req && !valid_q;
  assign late_w   = is_late(ev_t, now);
  assign link_bad = !link_up;
  assign issue    = fire && !late_w && !link_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      late_q  <= 1'b0;
      link_q  <= 1'b0;
      ev_chan <= '0;
      ev_addr <= '0;
      ev_time <= '0;
      ev_data <= '0;
    end else begin
      if (valid_q && ev_ready) valid_q <= 1'b0;
      if (fire) begin
        late_q <= late_w;
        link_q <= link_bad;
      end else if (flag_clr) begin
        late_q <= 1'b0;
        link_q <= 1'b0;
      end
      if (issue) begin
        valid_q <= 1'b1;
        ev_chan <= chsel;
        ev_addr <= taddr;
        ev_time <= ev_t;
        ev_data <= payload;
      end
    end
  end

  assign ev_valid = valid_q;
  always_comb begin
    status_o          = '0;
    status_o[ST_BUSY] = valid_q;
    status_o[ST_LATE] = late_q;
    status_o[ST_LINK] = link_q;
  end

  assert_hold_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !ev_ready |=> valid_q && $stable(ev_time) && $stable(ev_data)
                             && $stable(ev_chan) && $stable(ev_addr));
  assert_late_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && late_w |=> !valid_q && late_q);
  assert_link_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && link_bad |=> !valid_q && link_q);
  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_req && !flag_clr |=> $stable(late_q) && $stable(link_q));
  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req && valid_q && !ev_ready |=> valid_q && $stable(ev_time)
                                           && $stable(late_q) && $stable(link_q));
  assert_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> valid_q && ev_time == $past(ev_t) && ev_chan == $past(chsel));
endmodule

// File: rtl/evt_out_regif.sv
module evt_out_regif
  import evt_pkg::*;
#(
  parameter int unsigned N_WORDS = 2,
  parameter int unsigned CH_W    = 8,
  parameter int unsigned EV_AW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [4:0]            wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [4:0]            rd_addr,
  output logic [31:0]           rd_data,
  input  logic                  link_up,
  output logic                  ev_valid,
  input  logic                  ev_ready,
  output logic [CH_W-1:0]       ev_chan,
  output logic [EV_AW-1:0]      ev_addr,
  output logic [63:0]           ev_time,
  output logic [32*N_WORDS-1:0] ev_data
);
  logic                  ctrl_restart, snap_req, commit_req, time_wr;
  logic [63:0]           count, snap;
  logic [CH_W-1:0]       chsel;
  logic [63:0]           ev_t;
  logic [EV_AW-1:0]      taddr;
  logic [32*N_WORDS-1:0] payload;
  logic [2:0]            status;

  assign ctrl_restart = wr_en && wr_addr == A_CTRL && wr_data[0];
  assign snap_req     = wr_en && wr_addr == A_SNAPREQ;
  assign commit_req   = wr_en && wr_addr == A_COMMIT;

  evt_time_counter #(.CW(64)) u_counter (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_restart), .snap_req(snap_req),
    .count_o(count), .snap_o(snap)
  );

  evt_regfile #(.N_WORDS(N_WORDS), .CH_W(CH_W), .EV_AW(EV_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chsel_o(chsel), .time_o(ev_t), .taddr_o(taddr), .payload_o(payload),
    .time_wr_o(time_wr)
  );

  evt_commit #(.N_WORDS(N_WORDS), .CH_W(CH_W), .EV_AW(EV_AW)) u_commit (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .flag_clr(ctrl_restart),
    .now(count), .link_up(link_up), .chsel(chsel), .ev_t(ev_t), .taddr(taddr),
    .payload(payload), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_chan(ev_chan),
    .ev_addr(ev_addr), .ev_time(ev_time), .ev_data(ev_data), .status_o(status)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CHSEL:   rd_data = 32'(chsel);
      A_TIME_LO: rd_data = ev_t[31:0];
      A_TIME_HI: rd_data = ev_t[63:32];
      A_TADDR:   rd_data = 32'(taddr);
      A_STATUS:  rd_data = 32'(status);
      A_SNAP_LO: rd_data = snap[31:0];
      A_SNAP_HI: rd_data = snap[63:32];
      default: ;
    endcase
    for (int i = 0; i < int'(N_WORDS); i++) begin
      if (rd_addr == payload_slot(i, N_WORDS)) rd_data = payload[32*i +: 32];
    end
  end

  assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_restart |=> status[ST_LATE] == 1'b0 && status[ST_LINK] == 1'b0);
  assert_busy_tracks_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !commit_req |=> !ev_valid);
endmodule

// File: tb/evt_out_regif_tb_top.sv
module evt_out_regif_tb_top;
  localparam int N = 2;
  localparam int CHW = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic link_up = 1'b1;
  logic ev_valid;
  logic ev_ready = 1'b0;
  logic [CHW-1:0] ev_chan;
  logic [AW-1:0] ev_addr;
  logic [63:0] ev_time;
  logic [32*N-1:0] ev_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_out_regif #(.N_WORDS(N), .CH_W(CHW), .EV_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .link_up(link_up), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_chan(ev_chan), .ev_addr(ev_addr), .ev_time(ev_time),
    .ev_data(ev_data)
  );

  // Bench-side restatements of the requirements.
  function automatic logic [4:0] slot_of(int idx);
    return 5'(16 + (N - 1) - idx);
  endfunction
  function automatic bit ref_late(logic [63:0] t, logic [63:0] c);
    return !(t >= c);
  endfunction
  function automatic logic [31:0] ref_status(bit busy, bit late, bit lnk);
    return {29'd0, lnk, late, busy};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic snap_now(output logic [63:0] c);
    logic [31:0] lo, hi;
    wr(5'h07, 32'd0);
    rd(5'h08, lo);
    rd(5'h09, hi);
    c = {hi, lo};
  endtask

  // Handshake a pending event after a stall of the given length.
  task automatic drain(int stall, string tag);
    logic [63:0] t0;
    t0 = ev_time;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk({tag, " R5 hold valid"}, 64'(ev_valid), 64'd1);
      chk({tag, " R5 hold time"}, ev_time, t0);
    end
    ev_ready = 1'b1;
    @(negedge clk);
    ev_ready = 1'b0;
    chk({tag, " R5 valid drops"}, 64'(ev_valid), 64'd0);
  endtask

  // Build one event whose time is offset from the counter at the commit edge.
  task automatic run_event(logic [CHW-1:0] ch, logic [AW-1:0] ta, logic [32*N-1:0] pl,
                           longint off, bit lk, int stall);
    logic [63:0] c, now_c, t;
    logic [31:0] st;
    bit late;
    snap_now(c);
    now_c = c + 64'(5 + N);
    t = now_c + 64'(off);
    wr(5'h01, 32'(ch));
    wr(5'h02, t[31:0]);
    wr(5'h03, t[63:32]);
    wr(5'h04, 32'(ta));
    for (int i = 0; i < N; i++) wr(slot_of(i), pl[32*i +: 32]);
    link_up = lk;
    wr(5'h05, 32'd0);
    link_up = 1'b1;
    late = ref_late(t, now_c);
    rd(5'h06, st);
    if (late || !lk) begin
      chk("R6/R7 no event", 64'(ev_valid), 64'd0);
      chk("R6/R7 status", 64'(st), 64'(ref_status(0, late, !lk)));
    end else begin
      chk("R4 valid", 64'(ev_valid), 64'd1);
      chk("R4 busy status", 64'(st), 64'(ref_status(1, 0, 0)));
      chk("R4 time", ev_time, t);
      chk("R4 chan", 64'(ev_chan), 64'(ch));
      chk("R4 addr", 64'(ev_addr), 64'(ta));
      chk("R2 payload", ev_data, pl);
      drain(stall, "R5");
      rd(5'h06, st);
      chk("R5 status idle", 64'(st), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, st;
    logic [63:0] c1, c2, t;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h06, v); chk("R1 status", 64'(v), 64'd0);
    chk("R1 valid", 64'(ev_valid), 64'd0);
    for (int i = 0; i < N; i++) begin
      rd(slot_of(i), v); chk("R1 payload", 64'(v), 64'd0);
    end
    rd(5'h08, v); chk("R1 snapshot", 64'(v), 64'd0);

    // R2 literal placement: word 0 at 0x11, word 1 at 0x10
    wr(5'h02, 32'h0001_0000);
    wr(5'h03, 32'h0000_0001);
    wr(5'h11, 32'hAAAA_0001);
    wr(5'h10, 32'hBBBB_0002);
    rd(5'h11, v); chk("R2 readback 0x11", 64'(v), 64'hAAAA_0001);
    wr(5'h05, 32'd0);
    chk("R2 ev_data order", ev_data, 64'hBBBB_0002_AAAA_0001);
    drain(0, "R2");

    // R3 both time halves wipe the payload
    wr(5'h10, 32'h1234_5678); wr(5'h11, 32'h9abc_def0);
    wr(5'h03, 32'd0);
    rd(5'h10, v); chk("R3 hi write clears w1", 64'(v), 64'd0);
    rd(5'h11, v); chk("R3 hi write clears w0", 64'(v), 64'd0);
    wr(5'h10, 32'h5555_0000);
    wr(5'h02, 32'd7);
    rd(5'h10, v); chk("R3 lo write clears", 64'(v), 64'd0);

    // R6 boundary: equal accepted, one less rejected
    run_event(8'h3, 16'h10, 64'h1, 0, 1'b1, 1);
    run_event(8'h4, 16'h11, 64'h2, -1, 1'b1, 0);
    // R8 flag stays set while idle
    repeat (4) @(negedge clk);
    rd(5'h06, st); chk("R8 late sticky", 64'(st), 64'd2);
    // accepted commit replaces flags
    run_event(8'h5, 16'h12, 64'h3, 50, 1'b1, 0);
    // R7 link fault then sticky
    run_event(8'h6, 16'h13, 64'h4, 20, 1'b0, 0);
    repeat (3) @(negedge clk);
    rd(5'h06, st); chk("R8 link sticky", 64'(st), 64'd4);

    // R9 commit while busy is ignored
    snap_now(c1);
    t = c1 + 64'd1000;
    wr(5'h02, t[31:0]); wr(5'h03, t[63:32]);
    wr(5'h05, 32'd0);
    chk("R9 first accepted", 64'(ev_valid), 64'd1);
    wr(5'h02, 32'd0); wr(5'h03, 32'd0);
    wr(5'h05, 32'd0);
    chk("R9 time unchanged", ev_time, t);
    rd(5'h06, st); chk("R9 status unchanged", 64'(st), 64'd1);
    drain(1, "R9");
    @(negedge clk);
    chk("R9 no second event", 64'(ev_valid), 64'd0);

    // R10 snapshot spacing and hold
    wr(5'h07, 32'd0); rd(5'h08, v); c1 = 64'(v);
    wr(5'h07, 32'd0); rd(5'h08, v); c2 = 64'(v);
    chk("R10 step of one", c2 - c1, 64'd1);
    repeat (5) @(negedge clk);
    rd(5'h08, v); chk("R10 snapshot holds", 64'(v), c2);

    // R11 restart
    run_event(8'h7, 16'h14, 64'h5, -3, 1'b1, 0);
    wr(5'h00, 32'd1);
    wr(5'h07, 32'd0);
    rd(5'h08, v); chk("R11 counter zero", 64'(v), 64'd0);
    rd(5'h06, st); chk("R11 flags cleared", 64'(st), 64'd0);

    // Random events
    for (int n = 0; n < 40; n++) begin
      longint off;
      bit lk;
      off = ($urandom % 4 == 0) ? longint'(1000 + $urandom % 5000)
                                : longint'($urandom % 7) - 3;
      lk = ($urandom % 8) != 0;
      run_event(CHW'($urandom), AW'($urandom), {$urandom, $urandom}, off, lk,
                int'($urandom % 4));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule